// File: doc/BRIEF.md
# Buffered Serial Word Transmitter

This block is the transmit side of a synchronous serial port working in its one-word-per-frame mode. A host writes parallel words into a small holding queue. The queue has one entry, or two entries when the optional second stage is switched on. At each frame start the block moves the oldest queued word into a shift register and sends it on the serial data line, most significant bit first, one bit per bit-clock rising edge. It then releases the line until the next frame start. If a frame holds several time slots, only the first slot carries data.

The bit clock reaches the block as a one-cycle strobe (`bit_tick`) in the system clock domain. Frame starts come from `sync_in`. With a continuous clock, a frame starts at any tick where the frame sync is high. With a gated clock, `sync_in` shows that the bit clock is running, and a frame starts at the first tick of each burst. An empty flag tells the host that the queue has drained, and an interrupt output reflects that flag when the host enables it. `sd_oe` tells the pad to drive the line; the pad is high impedance whenever it is low.

Top module: `bst_tx`

## Requirements
- R1: After reset, `tx_empty` is 1, `tx_irq` is 0 and `sd_oe` is 0.
- R2: A host write (`wr_en` high for one cycle) makes `tx_empty` 0 from the next cycle on.
- R3: A word is loaded only at a frame start while both `port_en` and `tx_en` are 1. A frame start is a tick with `sync_in` = 1 when `clk_gated` = 0. When `clk_gated` = 1, it is a tick with `sync_in` = 1 where `sync_in` was 0 at the previous tick. With either enable low, a frame start does not drive the line.
- R4: From the cycle after the loading tick, `sd_oe` is 1 and `sd_o` shows bit WORD_W-1. Each later tick moves to the next lower bit. The tick after bit 0 has been shown clears `sd_oe`.
- R5: The queue holds 1 word when `buf_en` = 0 and 2 words when `buf_en` = 1. Words leave in write order. `tx_empty` rises only when the last queued word has moved to the shift register.
- R6: A write to a full queue replaces the most recently written word.
- R7: A frame start with an empty queue resends the last word that was sent (zero after reset), and `tx_empty` stays 1.
- R8: After a word ends, `sd_oe` stays 0 through the remaining ticks and slots of the frame until the next frame start.
- R9: `tx_irq` is 1 exactly when `tx_empty` and `irq_en` are both 1.
- R10: When `port_en` or `tx_en` is 0 at an edge, `sd_oe` is 0 after that edge, even in the middle of a word.
- R11: In gated mode, a `sync_in` level that stays high over many ticks gives only one frame start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_en | input | 1 | Serial port enable |
| tx_en | input | 1 | Transmitter enable |
| buf_en | input | 1 | 1 = two-word queue, 0 = one word |
| clk_gated | input | 1 | 1 = gated bit clock, 0 = continuous with frame sync |
| irq_en | input | 1 | Empty interrupt enable |
| bit_tick | input | 1 | One-cycle strobe per bit-clock rising edge |
| sync_in | input | 1 | Frame sync (continuous) or clock-running level (gated) |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | WORD_W | Host write word |
| sd_o | output | 1 | Serial data value |
| sd_oe | output | 1 | Serial data drive enable |
| tx_empty | output | 1 | Queue drained flag |
| tx_irq | output | 1 | Empty interrupt |

## Verification
The bench builds the block with WORD_W = 8 and HAS_BUF = 1. This makes the two-deep queue, its ordering and its overwrite-when-full case reachable. Byte patterns whose top and bottom bits differ expose bit-order and window-length faults. A random phase switches `buf_en`, `clk_gated` and both enables on the fly, while ticks, syncs and writes come at random. It therefore reaches collisions of writes with loads, the shrinking of a full two-word queue, and gated bursts that begin in the middle of a word.

// File: rtl/bst_pkg.sv
package bst_pkg;
   typedef enum logic {
      CLK_CONT  = 1'b0,
      CLK_GATED = 1'b1
   } clk_mode_e;

   localparam int unsigned QUEUE_MAX = 2;
endpackage

// File: rtl/bst_frame_detect.sv
module bst_frame_detect
   import bst_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  clk_mode_e mode,
   input  logic      bit_tick,
   input  logic      sync_in,
   output logic      frame_start
);
   logic prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n)        prev_q <= 1'b0;
      else if (bit_tick) prev_q <= sync_in;
   end

   always_comb begin
      frame_start = bit_tick && sync_in;
      if (mode == CLK_GATED) frame_start = frame_start && !prev_q;
   end

   AST_GATED_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == CLK_GATED && bit_tick && sync_in) |=> !(frame_start && mode == CLK_GATED)); // R11
endmodule

// File: rtl/bst_word_queue.sv
module bst_word_queue
   import bst_pkg::*;
#(
   parameter int unsigned WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              two_deep,
   input  logic              push,
   input  logic [WORD_W-1:0] push_data,
   input  logic              pop,
   output logic [WORD_W-1:0] head_data,
   output logic [1:0]        count
);
   logic [WORD_W-1:0] q_q [QUEUE_MAX];
   logic [WORD_W-1:0] q_d [QUEUE_MAX];
   logic [1:0]        cnt_q, cnt_d, after_pop, cap;
   logic [1:0]        wr_idx;

   always_comb begin
      q_d       = q_q;
      after_pop = cnt_q;
      cap       = two_deep ? 2'd2 : 2'd1;
      if (pop && cnt_q != 2'd0) begin
         q_d[0]    = q_q[1];
         after_pop = cnt_q - 2'd1;
      end
      cnt_d  = after_pop;
      wr_idx = (after_pop < cap) ? after_pop : after_pop - 2'd1;
      if (push) begin
         q_d[wr_idx[0]] = push_data;
         if (after_pop < cap) cnt_d = after_pop + 2'd1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         for (int i = 0; i < QUEUE_MAX; i++) q_q[i] <= '0;
      end else begin
         cnt_q <= cnt_d;
         q_q   <= q_d;
      end
   end

   assign head_data = q_q[0];
   assign count     = cnt_q;

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= 2'd2); // R6
   AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> cnt_q != 2'd0); // R2
endmodule

// File: rtl/bst_shifter.sv
module bst_shifter #(
   parameter int unsigned WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              load,
   input  logic [WORD_W-1:0] load_word,
   input  logic              bit_tick,
   output logic              sd,
   output logic              active
);
   localparam int unsigned CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

   logic [WORD_W-1:0] sreg_q;
   logic [CNT_W-1:0]  left_q;
   logic              act_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sreg_q <= '0;
         left_q <= '0;
         act_q  <= 1'b0;
      end else if (!enable) begin
         act_q  <= 1'b0;
      end else if (load) begin
         sreg_q <= load_word;
         left_q <= LAST_IDX;
         act_q  <= 1'b1;
      end else if (bit_tick && act_q) begin
         if (left_q == '0) begin
            act_q <= 1'b0;
         end else begin
            sreg_q <= {sreg_q[WORD_W-2:0], 1'b0};
            left_q <= left_q - 1'b1;
         end
      end
   end

   assign sd     = sreg_q[WORD_W-1];
   assign active = act_q;

   AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_tick |=> $stable(sd)); // R4
   AST_DROP_EN: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !active); // R10
endmodule

// File: rtl/bst_tx.sv
module bst_tx
   import bst_pkg::*;
#(
   parameter int unsigned WORD_W  = 8,
   parameter bit          HAS_BUF = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              port_en,
   input  logic              tx_en,
   input  logic              buf_en,
   input  logic              clk_gated,
   input  logic              irq_en,
   input  logic              bit_tick,
   input  logic              sync_in,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   output logic              sd_o,
   output logic              sd_oe,
   output logic              tx_empty,
   output logic              tx_irq
);
   initial begin
      assert (WORD_W >= 2 && WORD_W <= 64)
         else $error("bst_tx: WORD_W must be in 2..64");
   end

   logic              enable, frame_start, load, two_deep;
   logic [WORD_W-1:0] head_data, last_q, send_word;
   logic [1:0]        count;
   clk_mode_e         mode;

   assign enable = port_en && tx_en;
   assign mode   = clk_mode_e'(clk_gated);

   generate
      if (HAS_BUF) begin : g_buf
         assign two_deep = buf_en;
      end else begin : g_nobuf
         assign two_deep = 1'b0;
      end
   endgenerate

   bst_frame_detect u_detect (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode        (mode),
      .bit_tick    (bit_tick),
      .sync_in     (sync_in),
      .frame_start (frame_start)
   );

   assign load      = frame_start && enable;
   assign send_word = (count != 2'd0) ? head_data : last_q;

   bst_word_queue #(.WORD_W(WORD_W)) u_queue (
      .clk       (clk),
      .rst_n     (rst_n),
      .two_deep  (two_deep),
      .push      (wr_en),
      .push_data (wr_data),
      .pop       (load),
      .head_data (head_data),
      .count     (count)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)    last_q <= '0;
      else if (load) last_q <= send_word;
   end

   bst_shifter #(.WORD_W(WORD_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (enable),
      .load      (load),
      .load_word (send_word),
      .bit_tick  (bit_tick),
      .sd        (sd_o),
      .active    (sd_oe)
   );

   assign tx_empty = (count == 2'd0);
   assign tx_irq   = tx_empty && irq_en;

   AST_START_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && port_en && tx_en) |=> sd_oe); // R3
   AST_RESEND_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (load && tx_empty && !wr_en) |=> tx_empty); // R7
endmodule

// File: tb/bst_tx_tb.sv
`timescale 1ns/1ps
module bst_tx_tb;
   localparam int W = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic port_en = 0, tx_en = 0, buf_en = 0, clk_gated = 0, irq_en = 0;
   logic bit_tick = 0, sync_in = 0, wr_en = 0;
   logic [W-1:0] wr_data = '0;
   logic sd_o, sd_oe, tx_empty, tx_irq;

   int total = 0, bad = 0;
   bit done = 0, mdl_on = 0;

   always #4 clk = ~clk;

   bst_tx #(.WORD_W(W), .HAS_BUF(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .port_en(port_en), .tx_en(tx_en),
      .buf_en(buf_en), .clk_gated(clk_gated), .irq_en(irq_en),
      .bit_tick(bit_tick), .sync_in(sync_in), .wr_en(wr_en),
      .wr_data(wr_data), .sd_o(sd_o), .sd_oe(sd_oe),
      .tx_empty(tx_empty), .tx_irq(tx_irq));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
      end
   endtask

   // reference model built from the requirements
   logic [W-1:0] m_q[2];
   logic [W-1:0] m_last, m_sreg;
   int m_cnt, m_bits;
   bit m_act, m_prev;

   function automatic logic m_start(input logic tk, input logic sy, input logic gt, input bit pv);
      return tk && sy && (!gt || !pv);
   endfunction

   function automatic int m_cap(input logic be);
      return be ? 2 : 1;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_q[0] = '0; m_q[1] = '0; m_last = '0; m_sreg = '0;
         m_cnt = 0; m_bits = 0; m_act = 0; m_prev = 0;
      end else begin
         bit st, en;
         logic [W-1:0] w;
         st = m_start(bit_tick, sync_in, clk_gated, m_prev);
         en = port_en && tx_en;
         if (bit_tick) m_prev = sync_in;
         if (!en) m_act = 0;
         else if (st) begin
            if (m_cnt > 0) begin
               w = m_q[0]; m_q[0] = m_q[1]; m_cnt--;
            end else w = m_last;
            m_last = w; m_sreg = w; m_bits = W - 1; m_act = 1;
         end else if (bit_tick && m_act) begin
            if (m_bits == 0) m_act = 0;
            else begin m_sreg = m_sreg << 1; m_bits--; end
         end
         if (wr_en) begin
            if (m_cnt < m_cap(buf_en)) begin m_q[m_cnt] = wr_data; m_cnt++; end
            else m_q[m_cnt-1] = wr_data;
         end
      end
   end

   always @(negedge clk) begin
      if (mdl_on && !done) begin
         chk("R4", sd_oe, m_act);
         if (m_act) chk("R4", sd_o, m_sreg[W-1]);
         chk("R5", tx_empty, m_cnt == 0);
         chk("R9", tx_irq, (m_cnt == 0) && irq_en);
      end
   end

   // one system cycle; inputs change 1 ns after the edge
   task automatic step(input logic tk, input logic sy, input logic wr, input logic [W-1:0] d);
      bit_tick = tk; sync_in = sy; wr_en = wr; wr_data = d;
      @(posedge clk); #1;
      bit_tick = 0; wr_en = 0;
   endtask

   task automatic send_frame(input logic [W-1:0] w, input logic hold, input logic exp_empty);
      step(1, 1, 0, '0);
      chk("R3", sd_oe, 1'b1);
      chk("R4", sd_o, w[W-1]);
      chk("R5", tx_empty, exp_empty);
      for (int k = W - 2; k >= 0; k--) begin
         step(0, hold, 0, '0);
         step(1, hold, 0, '0);
         chk("R4", sd_o, w[k]);
      end
      step(1, hold, 0, '0);
      chk("R4", sd_oe, 1'b0);
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         done = 1; bad++; total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      mdl_on = 1;
      chk("R1", tx_empty, 1'b1);
      chk("R1", tx_irq, 1'b0);
      chk("R1", sd_oe, 1'b0);
      port_en = 1; tx_en = 1;

      step(0, 0, 1, 8'hA5);
      chk("R2", tx_empty, 1'b0);
      irq_en = 1; #1;
      chk("R9", tx_irq, 1'b0);
      send_frame(8'hA5, 1'b0, 1'b1);
      chk("R9", tx_irq, 1'b1);
      repeat (10) step(1, 0, 0, '0);
      chk("R8", sd_oe, 1'b0);

      send_frame(8'hA5, 1'b0, 1'b1);  // empty queue resends
      chk("R7", tx_empty, 1'b1);

      tx_en = 0;
      step(0, 0, 1, 8'h11);
      step(1, 1, 0, '0);
      chk("R3", sd_oe, 1'b0);
      tx_en = 1;
      step(1, 1, 0, '0);
      chk("R3", sd_o, 1'b0);
      step(1, 0, 0, '0);
      port_en = 0;
      step(0, 0, 0, '0);
      chk("R10", sd_oe, 1'b0);
      port_en = 1;
      step(0, 0, 0, '0);

      buf_en = 1;
      step(0, 0, 1, 8'h3C);
      step(0, 0, 1, 8'hC3);
      step(0, 0, 1, 8'h81);
      send_frame(8'h3C, 1'b0, 1'b0);
      chk("R5", tx_empty, 1'b0);
      send_frame(8'h81, 1'b0, 1'b1);
      chk("R6", tx_empty, 1'b1);

      clk_gated = 1;
      step(0, 0, 1, 8'h5A);
      send_frame(8'h5A, 1'b1, 1'b1);
      repeat (5) step(1, 1, 0, '0);
      chk("R11", sd_oe, 1'b0);
      step(1, 0, 0, '0);
      step(1, 1, 0, '0);
      chk("R11", sd_oe, 1'b1);
      chk("R7", sd_o, 1'b0);
      clk_gated = 0;
      step(1, 0, 0, '0);

      for (int n = 0; n < 6000; n++) begin
         logic tk, sy, wr;
         if ($urandom % 200 == 0) port_en = ~port_en;
         if ($urandom % 200 == 0) tx_en = ~tx_en;
         if ($urandom % 300 == 0) buf_en = ~buf_en;
         if ($urandom % 50 == 0) irq_en = ~irq_en;
         if ($urandom % 600 == 0) clk_gated = ~clk_gated;
         if (!port_en && $urandom % 4 == 0) port_en = 1;
         if (!tx_en && $urandom % 4 == 0) tx_en = 1;
         tk = ($urandom % 3 == 0);
         if (clk_gated) sy = ($urandom % 40 == 0) ? ~sync_in : sync_in;
         else sy = tk && ($urandom % 14 == 0);
         wr = ($urandom % 9 == 0);
         step(tk, sy, wr, W'($urandom));
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule